// File: doc/BRIEF.md
# Fall-Through Bubble Shift FIFO

This block is a first-in-first-out buffer made of a chain of identical word stages rather than a RAM with pointers. Each stage holds one data word and a single occupancy marker. A word written at the input end moves toward the output end by one stage per clock while the next stage is vacant. Vacancies travel the other way, toward the input. The first stage therefore reports whether the buffer can take a word, and the last stage reports whether the oldest word is ready to leave.

The model is synchronous to one clock. Every stage decides its next state from the markers as they stood at the start of the cycle, so a word never skips a stage. A deeper buffer is made by chaining instances: the upstream `out_ready` and `dout` feed the downstream `shift_in` and `din`, and the downstream `in_ready` drives the upstream `shift_out`. The output word is forced to zero while the output enable is low.

Top module: `ripple_fifo`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_ready` is 0, and every stage marker is clear.
- R2: Words leave in the order they were accepted, with their values unchanged.
- R3: With the default depth of 16, the buffer accepts exactly 16 words without a read. Once those words have settled, `in_ready` is 0.
- R4: A `shift_in` pulse while `in_ready` is 0 is ignored. No extra word appears at the output later.
- R5: A `shift_out` pulse while `out_ready` is 0 is ignored and changes no stage.
- R6: A word accepted by an empty buffer of depth D raises `out_ready` exactly D-1 clock edges after the edge that accepted it.
- R7: A word or a vacancy moves at most one stage per clock. After a read from a full, settled buffer, `in_ready` returns to 1 exactly D-1 edges after the read edge.
- R8: While `oe` is 0, `dout` is all zeros. While `oe` is 1 and `out_ready` is 1, `dout` shows the oldest word.
- R9: An accepted read (`shift_out` with `out_ready` 1) clears the last stage, so `out_ready` is 0 in the following cycle. An accepted write likewise makes `in_ready` 0 in the following cycle.
- R10: A write and a read accepted at the same edge both take effect, and the order of the remaining words is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| shift_in | input | 1 | Write strobe; accepted when `in_ready` is 1 |
| din | input | WIDTH | Word to write |
| shift_out | input | 1 | Read strobe; accepted when `out_ready` is 1 |
| oe | input | 1 | Output enable for `dout` |
| dout | output | WIDTH | Oldest word, or zero while `oe` is 0 |
| in_ready | output | 1 | High when the first stage is vacant |
| out_ready | output | 1 | High when the last stage holds a word |

## Verification
A write at the input end and a read at the output end can land on the same clock edge. They touch opposite ends of the chain but share the ripple in between. The bench leaves a few words settled in the buffer and then raises both strobes in one cycle. It checks that the read word is the oldest one, and that the rest drain with the new word last and nothing lost or repeated. The bench also pulses each strobe while its ready flag is low and judges the result by the count and order of the words that leave afterwards.

// File: rtl/ripple_fifo_pkg.sv
package ripple_fifo_pkg;
  localparam int unsigned RF_DEF_DEPTH = 16;
  localparam int unsigned RF_DEF_WIDTH = 4;

  // Handshake state of one stage in a cycle
  typedef struct packed {
    logic take;  // copy from predecessor
    logic give;  // hand word to successor
  } rf_move_t;
endpackage

// File: rtl/ripple_fifo_rstsync.sv
module ripple_fifo_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/ripple_fifo_stage.sv
module ripple_fifo_stage
  import ripple_fifo_pkg::*;
#(
  parameter int unsigned WIDTH = RF_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prev_full,
  input  logic [WIDTH-1:0] prev_data,
  input  logic             next_open,
  output logic             full,
  output logic [WIDTH-1:0] data
);
  rf_move_t   mv;
  logic       full_d;
  logic       full_q;
  logic [WIDTH-1:0] data_q;

  always_comb begin
    mv.take = ~full_q & prev_full;
    mv.give = full_q & next_open;
    full_d  = mv.take | (full_q & ~mv.give);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
    end
  end

  // data register: clock enable only on a take, no reset needed
  always_ff @(posedge clk) begin
    if (mv.take) begin
      data_q <= prev_data;
    end
  end

  assign full = full_q;
  assign data = data_q;
endmodule

// File: rtl/ripple_fifo_outgate.sv
module ripple_fifo_outgate #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             oe,
  input  logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] gated
);
  always_comb begin
    gated = oe ? word : '0;
  end
endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo
  import ripple_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = RF_DEF_DEPTH,
  parameter int unsigned WIDTH = RF_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] din,
  input  logic             shift_out,
  input  logic             oe,
  output logic [WIDTH-1:0] dout,
  output logic             in_ready,
  output logic             out_ready
);
  localparam int unsigned LAST = DEPTH - 1;

  logic                   rst_q_n;
  logic [DEPTH-1:0]       stage_mark;
  logic [WIDTH-1:0]       stage_word [DEPTH];
  logic [DEPTH-1:0]       feed_full;
  logic [WIDTH-1:0]       feed_word  [DEPTH];
  logic [DEPTH-1:0]       drain_open;

  ripple_fifo_rstsync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        assign feed_full[gi] = shift_in;
        assign feed_word[gi] = din;
      end else begin : g_body
        assign feed_full[gi] = stage_mark[gi-1];
        assign feed_word[gi] = stage_word[gi-1];
      end

      if (gi == LAST) begin : g_tail
        assign drain_open[gi] = shift_out;
      end else begin : g_mid
        assign drain_open[gi] = ~stage_mark[gi+1];
      end

      ripple_fifo_stage #(.WIDTH(WIDTH)) u_stage (
        .clk       (clk),
        .rst_n     (rst_q_n),
        .prev_full (feed_full[gi]),
        .prev_data (feed_word[gi]),
        .next_open (drain_open[gi]),
        .full      (stage_mark[gi]),
        .data      (stage_word[gi])
      );
    end
  endgenerate

  ripple_fifo_outgate #(.WIDTH(WIDTH)) u_gate (
    .oe    (oe),
    .word  (stage_word[LAST]),
    .gated (dout)
  );

  assign in_ready  = ~stage_mark[0];
  assign out_ready = stage_mark[LAST];
endmodule

// File: rtl/ripple_fifo_chk.sv
module ripple_fifo_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 4
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             shift_in,
  input logic             shift_out,
  input logic             oe,
  input logic [WIDTH-1:0] dout,
  input logic             in_ready,
  input logic             out_ready,
  input logic [DEPTH-1:0] stage_mark
);
  // R1: markers are clear while the internal reset is held
  p_reset_empty_r1: assert property (@(posedge clk)
    !rst_q_n |-> (stage_mark == '0 && in_ready && !out_ready));

  // R9: an accepted write occupies the head stage for the next cycle
  p_write_blocks_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (shift_in && in_ready) |=> !in_ready);

  // R9: an accepted read vacates the tail stage
  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (shift_out && out_ready) |=> !out_ready);

  // R5: a read from an empty buffer with no write leaves it empty
  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (stage_mark == '0 && !shift_in) |=> (stage_mark == '0));

  // R7: the tail can only fill from the stage just before it
  p_one_step_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(out_ready) |-> $past(stage_mark[DEPTH-2]));

  // R7: the head can only be vacated by a move into stage 1
  p_head_leaves_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(in_ready) |-> !$past(stage_mark[1]));

  // R8: disabled output is idle
  p_idle_out_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    !oe |-> (dout == '0));
endmodule

bind ripple_fifo ripple_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .shift_in   (shift_in),
  .shift_out  (shift_out),
  .oe         (oe),
  .dout       (dout),
  .in_ready   (in_ready),
  .out_ready  (out_ready),
  .stage_mark (stage_mark)
);

// File: tb/ripple_fifo_test.sv
`timescale 1ns/1ps
module ripple_fifo_test;
  localparam int DEPTH = 16;
  localparam int WIDTH = 4;

  logic             clk;
  logic             rst_n;
  logic             shift_in;
  logic [WIDTH-1:0] din;
  logic             shift_out;
  logic             oe;
  logic [WIDTH-1:0] dout;
  logic             in_ready;
  logic             out_ready;

  int n_checks;
  int n_fails;

  ripple_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_in  (shift_in),
    .din       (din),
    .shift_out (shift_out),
    .oe        (oe),
    .dout      (dout),
    .in_ready  (in_ready),
    .out_ready (out_ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  task automatic check(string req, int actual, int expected);
    n_checks++;
    if (actual != expected) begin
      n_fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // write one word once in_ready is seen high
  task automatic push(logic [WIDTH-1:0] w);
    while (!in_ready) tick();
    shift_in = 1'b1;
    din      = w;
    tick();
    shift_in = 1'b0;
  endtask

  // read one word once out_ready is seen high, comparing against exp
  task automatic pop(string req, logic [WIDTH-1:0] exp);
    while (!out_ready) tick();
    check(req, int'(dout), int'(exp));
    shift_out = 1'b1;
    tick();
    shift_out = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(3);
  endtask

  task automatic t_reset();
    check("R1 in_ready after reset", int'(in_ready), 1);
    check("R1 out_ready after reset", int'(out_ready), 0);
  endtask

  task automatic t_latency();
    push(4'hA);
    tick(DEPTH - 2);
    check("R6 out_ready one edge early", int'(out_ready), 0);
    tick();
    check("R6 out_ready on time", int'(out_ready), 1);
    pop("R2 single word value", 4'hA);
    check("R9 out_ready after read", int'(out_ready), 0);
  endtask

  task automatic t_fill_drain();
    for (int i = 0; i < DEPTH; i++) push(4'(i + 1));
    tick(2 * DEPTH);
    check("R3 in_ready when full", int'(in_ready), 0);
    check("R3 out_ready when full", int'(out_ready), 1);
    // R4: write attempt while full
    shift_in = 1'b1;
    din      = 4'hF;
    tick();
    shift_in = 1'b0;
    pop("R2 first of full", 4'(1));
    tick(DEPTH - 2);
    check("R7 in_ready one edge early", int'(in_ready), 0);
    tick();
    check("R7 bubble reaches head", int'(in_ready), 1);
    for (int i = 1; i < DEPTH; i++) pop("R2 drain order", 4'(i + 1));
    tick(2 * DEPTH);
    check("R4 no extra word", int'(out_ready), 0);
    check("R4 in_ready after drain", int'(in_ready), 1);
  endtask

  task automatic t_empty_read();
    shift_out = 1'b1;
    tick(2);
    shift_out = 1'b0;
    check("R5 out_ready after empty read", int'(out_ready), 0);
    check("R5 in_ready after empty read", int'(in_ready), 1);
    push(4'h5);
    tick(DEPTH);
    pop("R5 word after empty read", 4'h5);
    tick(2 * DEPTH);
    check("R5 nothing more", int'(out_ready), 0);
  endtask

  task automatic t_oe();
    push(4'h9);
    tick(DEPTH);
    oe = 1'b0;
    tick();
    check("R8 dout idle when disabled", int'(dout), 0);
    check("R8 word kept while disabled", int'(out_ready), 1);
    oe = 1'b1;
    tick();
    check("R8 dout when enabled", int'(dout), 9);
    pop("R8 word after enable", 4'h9);
  endtask

  task automatic t_concurrent();
    push(4'h3);
    push(4'h6);
    push(4'hC);
    tick(2 * DEPTH);
    check("R10 ready before dual", int'(in_ready & out_ready), 1);
    check("R10 oldest before dual", int'(dout), 3);
    shift_in  = 1'b1;
    din       = 4'h7;
    shift_out = 1'b1;
    tick();
    shift_in  = 1'b0;
    shift_out = 1'b0;
    check("R10 read cleared tail", int'(out_ready), 0);
    check("R10 write occupied head", int'(in_ready), 0);
    pop("R10 order second", 4'h6);
    pop("R10 order third", 4'hC);
    pop("R10 new word last", 4'h7);
    tick(2 * DEPTH);
    check("R10 empty after dual", int'(out_ready), 0);
  endtask

  initial begin
    n_checks  = 0;
    n_fails   = 0;
    shift_in  = 1'b0;
    shift_out = 1'b0;
    din       = '0;
    oe        = 1'b1;
    do_reset();
    t_reset();
    t_latency();
    t_fill_drain();
    t_empty_read();
    t_oe();
    t_concurrent();
    // R1: reset in the middle of traffic empties the buffer
    push(4'h2);
    push(4'h4);
    do_reset();
    t_reset();
    tick(2 * DEPTH);
    check("R1 stays empty after reset", int'(out_ready), 0);
    summary();
    $finish;
  end
endmodule